// File: doc/BRIEF.md
# Reset Cause and Soft Reset Register

This block holds a single 32-bit register that tells software why the system last came out of reset, and lets software start a new reset. Five bits at the top of the word carry meaning: a power-on flag, two soft-trigger flags (soft power-on and soft external-initiated reset) and two button flags (button power-on and button external-initiated reset). The power-on flag and the two button flags are cleared by writing one. The two soft flags are set by writing one. A write that sets a soft flag also raises a one-cycle reset request towards the system reset sequencer.

A small saturating counter records how many system resets the block has seen. When a system reset event arrives while the counter is at zero, the register is loaded with only the power-on flag set. Later resets leave the register as it is. A soft power-on write returns the counter to zero, so the next system reset counts as a fresh power-on. Button presses reach the block as already-debounced single-cycle event inputs, and each one sets its own flag.

The register sits at the odd 32-bit word of an 8-byte slot on a simple register bus. The even word always reads zero and ignores writes.

Top module: `rstc_reg`

## Requirements
- R1: After the asynchronous block reset, the register reads 0x00000000, the reset request is low and the reset counter is zero.
- R2: Every write is masked to bits 31:27 before it is used. Bits 26:0 of the register always read zero.
- R3: Writing one to bit 31 (power-on), bit 28 (button power-on) or bit 27 (button external reset) at the odd word clears that bit. Writing zero to these bits leaves them unchanged.
- R4: Writing one to bit 30 (soft power-on) or bit 29 (soft external reset) at the odd word sets that bit. Writing zero never clears either bit.
- R5: A write at the odd word with bit 30 set clears the reset counter and drives rst_req_o high for exactly the one cycle that follows the write edge. The updated register value is visible in that same cycle.
- R6: A write at the odd word with bit 29 set and bit 30 clear also gives the one-cycle rst_req_o pulse. Writes with neither bit set give no pulse.
- R7: A sys_reset_i event while the counter is zero loads the register with exactly 0x80000000. This overrides any write or button event in the same cycle. The counter then increments.
- R8: A sys_reset_i event while the counter is nonzero leaves the register to the normal write and button update.
- R9: btn_por_i sets bit 28 and btn_xir_i sets bit 27. A button event wins over a write-one-to-clear of the same bit in the same cycle.
- R10: The odd word (address bit 2 = 1) reads the register. The even word reads zero, and a write to it changes neither the register nor the counter, and gives no request pulse.
- R11: The counter saturates at its maximum value instead of wrapping. A long run of system resets without a soft power-on therefore never loads the power-on flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the slot; bit 2 selects the odd word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_reset_i | input | 1 | One-cycle event: a system reset took place |
| btn_por_i | input | 1 | One-cycle event: button power-on reset |
| btn_xir_i | input | 1 | One-cycle event: button external reset |
| rst_req_o | output | 1 | One-cycle reset request to the sequencer |
| reg_value_o | output | 32 | Current register value |

## Verification
The bench goes after the mixed write semantics. It writes all-ones, which must clear the status flags and set the soft flags in one step. A design with the masks swapped would keep the power-on flag and drop the soft flags. A soft power-on write followed by a system reset must reload the power-on flag. A design that forgot to clear the counter would leave the register untouched.

The bench also runs more than sixteen system resets after a clear. A wrapping counter would wrongly reload the power-on flag. It fires a button event in the same cycle as a clear of the same flag, where a design with the wrong priority loses the flag. It also writes the even word, where a design with a bad decode would change state or pulse the request.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int REG_W = 32;

  // flag positions; software decodes these bits
  localparam int BIT_POR  = 31;
  localparam int BIT_SPOR = 30;
  localparam int BIT_SXIR = 29;
  localparam int BIT_BPOR = 28;
  localparam int BIT_BXIR = 27;

  localparam logic [REG_W-1:0] MASK_LIVE = 32'hF800_0000;
  localparam logic [REG_W-1:0] MASK_W1C  = 32'h9800_0000;
  localparam logic [REG_W-1:0] MASK_SET  = 32'h6000_0000;
  localparam logic [REG_W-1:0] VAL_FIRST = 32'h8000_0000;

  // odd word of the 8-byte slot is selected by this address bit
  localparam int WORD_SEL = 2;

  typedef struct packed {
    logic sys_rst;
    logic btn_por;
    logic btn_xir;
  } rstc_evt_t;
endpackage

// File: rtl/rstc_count.sv
module rstc_count #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic first
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign first = (cnt_q == '0);
endmodule

// File: rtl/rstc_merge.sv
module rstc_merge
  import rstc_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             wr_odd,
  input  logic [REG_W-1:0] wdata,
  input  rstc_evt_t        evt,
  input  logic             first,
  output logic [REG_W-1:0] nxt,
  output logic             req,
  output logic             cnt_clr
);
  logic [REG_W-1:0] wv;

  always_comb begin
    wv      = wr_odd ? (wdata & MASK_LIVE) : '0;
    nxt     = (cur & ~(wv & MASK_W1C)) | (wv & MASK_SET);
    if (evt.btn_por) nxt[BIT_BPOR] = 1'b1;
    if (evt.btn_xir) nxt[BIT_BXIR] = 1'b1;
    if (evt.sys_rst && first) nxt = VAL_FIRST;
    req     = wv[BIT_SPOR] | wv[BIT_SXIR];
    cnt_clr = wv[BIT_SPOR];
  end
endmodule

// File: rtl/rstc_reg.sv
module rstc_reg
  import rstc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sys_reset_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              rst_req_o,
  output logic [31:0]       reg_value_o
);
  logic             odd_sel;
  logic             wr_odd;
  rstc_evt_t        evt;
  logic             rst_first;
  logic             cnt_clr;
  logic             req_d;
  logic [REG_W-1:0] val_q;
  logic [REG_W-1:0] val_d;
  logic             val_en;
  logic             req_q;

  assign odd_sel = bus_addr[WORD_SEL];
  assign wr_odd  = bus_sel & bus_we & odd_sel;
  assign evt     = '{sys_rst: sys_reset_i, btn_por: btn_por_i, btn_xir: btn_xir_i};

  rstc_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (sys_reset_i),
    .first (rst_first)
  );

  rstc_merge u_merge (
    .cur     (val_q),
    .wr_odd  (wr_odd),
    .wdata   (bus_wdata),
    .evt     (evt),
    .first   (rst_first),
    .nxt     (val_d),
    .req     (req_d),
    .cnt_clr (cnt_clr)
  );

  assign val_en = wr_odd | sys_reset_i | btn_por_i | btn_xir_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign rst_req_o   = req_q;
  assign reg_value_o = val_q;
  assign bus_rdata   = (bus_sel && odd_sel) ? val_q : '0;
endmodule

// File: rtl/rstc_reg_chk.sv
module rstc_reg_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              sys_reset_i,
  input logic              btn_por_i,
  input logic              btn_xir_i,
  input logic              rst_req_o,
  input logic [31:0]       reg_value_o,
  input logic              first_i
);
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_value_o[26:0] == 27'd0);

  p_w1c_por_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[2] && bus_wdata[31] && !sys_reset_i)
    |=> !reg_value_o[31]);

  p_soft_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_value_o[30] && !sys_reset_i) |=> reg_value_o[30]);

  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(bus_sel && bus_we && bus_addr[2]
                        && (bus_wdata[30] || bus_wdata[29])));

  p_first_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_i && first_i) |=> (reg_value_o == 32'h8000_0000));

  p_btn_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_por_i && !(sys_reset_i && first_i)) |=> reg_value_o[28]);

  p_even_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_addr[2]) |-> (bus_rdata == 32'd0));
endmodule

bind rstc_reg rstc_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .sys_reset_i (sys_reset_i),
  .btn_por_i   (btn_por_i),
  .btn_xir_i   (btn_xir_i),
  .rst_req_o   (rst_req_o),
  .reg_value_o (reg_value_o),
  .first_i     (rst_first)
);

// File: tb/tb_rstc_reg.sv
`timescale 1ns/1ps
module tb_rstc_reg;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam logic [ADDR_W-1:0] A_ODD  = 4'h4;
  localparam logic [ADDR_W-1:0] A_EVEN = 4'h0;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              sys_reset_i, btn_por_i, btn_xir_i;
  logic              rst_req_o;
  logic [31:0]       reg_value_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_reg;
  int          m_cnt;
  logic        m_req;

  always #5 clk = ~clk;

  rstc_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_reset_i(sys_reset_i), .btn_por_i(btn_por_i), .btn_xir_i(btn_xir_i),
    .rst_req_o(rst_req_o), .reg_value_o(reg_value_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_next(input logic [31:0] cur, input logic wr,
      input logic [31:0] wd, input logic sys, input logic bp, input logic bx, input int cnt);
    logic [31:0] v, n;
    v = wr ? (wd & 32'hF800_0000) : 32'd0;
    n = (cur & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
    if (bp) n[28] = 1'b1;
    if (bx) n[27] = 1'b1;
    if (sys && cnt == 0) n = 32'h8000_0000;
    return n;
  endfunction

  task automatic idle();
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    sys_reset_i = 0; btn_por_i = 0; btn_xir_i = 0;
  endtask

  // called at a negedge; drives one cycle and checks at the following negedge
  task automatic step(input string tag, input logic sel, input logic we,
      input logic [ADDR_W-1:0] a, input logic [31:0] wd,
      input logic sys, input logic bp, input logic bx);
    logic wr;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    sys_reset_i = sys; btn_por_i = bp; btn_xir_i = bx;
    wr = sel && we && a[2];
    m_reg = f_next(m_reg, wr, wd, sys, bp, bx, m_cnt);
    m_req = wr && (wd[30] || wd[29]);
    if (wr && wd[30]) m_cnt = 0;
    else if (sys && m_cnt != CNT_MAX) m_cnt++;
    @(negedge clk);
    idle();
    check({tag, " reg"}, reg_value_o, m_reg);
    check({tag, " req"}, {31'd0, rst_req_o}, {31'd0, m_req});
  endtask

  task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    idle();
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_n = 0;
    m_reg = 0; m_cnt = 0; m_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reg", reg_value_o, 32'd0);
    check("R1 req", {31'd0, rst_req_o}, 32'd0);
    rd("R1 read", A_ODD, 32'd0);
    // R7 first system reset loads power-on flag only
    step("R7 first", 0, 0, A_EVEN, 0, 1, 0, 0);
    check("R7 value", reg_value_o, 32'h8000_0000);
    // R6 soft external write, R4 set
    step("R6 sxir", 1, 1, A_ODD, 32'h2000_0000, 0, 0, 0);
    check("R6 pulse", {31'd0, rst_req_o}, 32'd0 + 1);
    @(negedge clk);
    check("R6 pulse end", {31'd0, rst_req_o}, 32'd0);
    // R8 later system reset keeps the value
    step("R8 keep", 0, 0, A_EVEN, 0, 1, 0, 0);
    check("R8 value", reg_value_o, 32'hA000_0000);
    // R3 R4 zero write has no effect
    step("R4 zero write", 1, 1, A_ODD, 32'h0000_0000, 0, 0, 0);
    // R2 R3 R5 all-ones write
    step("R5 all ones", 1, 1, A_ODD, 32'hFFFF_FFFF, 0, 0, 0);
    check("R2 masked", reg_value_o, 32'h6000_0000);
    // R5 counter cleared: next system reset reloads power-on flag
    step("R5 reload", 0, 0, A_EVEN, 0, 1, 0, 0);
    check("R5 reload value", reg_value_o, 32'h8000_0000);
    // R9 buttons
    step("R9 bpor", 0, 0, A_EVEN, 0, 0, 1, 0);
    step("R9 bxir", 0, 0, A_EVEN, 0, 0, 0, 1);
    check("R9 both", reg_value_o, 32'h9800_0000);
    step("R9 set wins", 1, 1, A_ODD, 32'h1000_0000, 0, 1, 0);
    check("R9 kept", reg_value_o, 32'h9800_0000);
    // R3 clear button external flag
    step("R3 clear bxir", 1, 1, A_ODD, 32'h0800_0000, 0, 0, 0);
    check("R3 value", reg_value_o, 32'h9000_0000);
    // R10 even word
    step("R10 even write", 1, 1, A_EVEN, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R10 even read", A_EVEN, 32'd0);
    rd("R10 odd read", A_ODD, 32'h9000_0000);
    // R11 saturation
    for (int i = 0; i < 20; i++) step("R11 run", 0, 0, A_EVEN, 0, 1, 0, 0);
    step("R11 clear", 1, 1, A_ODD, 32'h9800_0000, 0, 0, 0);
    step("R11 no reload", 0, 0, A_EVEN, 0, 1, 0, 0);
    check("R11 value", reg_value_o, 32'd0);
    // R7 override: first reset wins over a write in the same cycle
    step("R7 soft por", 1, 1, A_ODD, 32'h4000_0000, 0, 0, 0);
    step("R7 override", 1, 1, A_ODD, 32'h2800_0000, 1, 1, 1);
    check("R7 override value", reg_value_o, 32'h8000_0000);
    // random mix against the model, R2..R11
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      logic [3:0]  k;
      wd = $urandom();
      k  = 4'($urandom());
      step("R2-mix", k[0], k[1], k[2] ? A_ODD : A_EVEN, wd,
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 5) == 0));
    end
    rd("R10 final read", A_ODD, m_reg);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule